// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block takes a stereo PCM stream made of a bit clock, an LR word clock and one serial data line, and turns it into parallel samples. Six framings are handled by a single shift engine. There are right-justified words of 16, 20 and 24 bits, a 24-bit left-justified word, and 16- and 24-bit I2S words. A 3-bit format code selects the framing. A polarity input selects which LR clock level stands for the left channel. Each completed stereo frame gives a sign-extended 24-bit left sample, a sign-extended 24-bit right sample and a one-cycle valid pulse.

The three serial inputs pass through synchronisers into the system clock domain. The system clock must run several times faster than the bit clock. Every rising edge of the bit clock samples one data bit and the LR level at the same moment. A change in the sampled LR level marks the start of a new half-period.

A framing FSM has three states:
- ST_ALIGN is entered after reset. It waits for an LR change into the left level and ignores everything before it.
- ST_LEFT collects the left word.
- ST_RIGHT collects the right word.

The FSM has these transitions:
- T_START goes from ALIGN to LEFT on a change into the left level.
- T_L2R goes from LEFT to RIGHT on a change into the right level, and stores the left word.
- T_EMIT goes from RIGHT to LEFT on a change into the left level. It presents both words and pulses valid.
- T_RESYNC_L restarts LEFT when a change leads into the left level again. No word is stored.
- T_RESYNC_R goes from RIGHT to ALIGN when a change leads into the right level again.

Right-justified words are taken from a register that keeps the most recent 24 bits, read when the LR level changes. Left-justified and I2S words are gathered in a counted window that starts at the LR change.

Top module: `audio_serial_rx`

## Requirements
- R1: While reset is low and right after it, o_valid is 0 and o_left and o_right are 0.
- R2: For fmt 3'b000, 3'b001 and 3'b010 (right-justified, 16, 20 and 24 bits), the word is the last N bits sampled before the bit-clock rise where the LR level changes. The word is sent MSB first and sign-extended from bit N-1 to 24 bits.
- R3: For fmt 3'b011 (left-justified, 24 bits), the MSB is the bit sampled on the first bit-clock rise that shows the new LR level. It is followed by the next 23 bits.
- R4: For fmt 3'b100 (16-bit I2S) and 3'b101 (24-bit I2S), the MSB is the bit sampled on the second bit-clock rise of the half-period. The bit on the first rise is ignored. 16-bit words are sign-extended.
- R5: For fmt 3'b110 and 3'b111 (reserved), both samples are 0 and o_valid still pulses once per frame.
- R6: With lr_pol = 0, a high LR level marks the left channel. With lr_pol = 1, a low LR level marks the left channel.
- R7: o_valid is high for exactly one clock per frame, once the right half has ended. o_left and o_right change only in that cycle.
- R8: After reset, no frame is reported until a complete left half that begins at an LR change into the left level has been followed by a right half. A leading right half yields no pulse.
- R9: Data bits outside the selected word within a half-period do not affect the samples.
- R10: A bit-clock rise is seen at most once per rise, so two consecutive system cycles never both register a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than bclk |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Serial bit clock, data sampled on its rising edge |
| lrclk | input | 1 | LR word clock |
| sdata | input | 1 | Serial audio data |
| fmt | input | 3 | Framing code {i2s, wl1, wl0} as listed in R2 to R5 |
| lr_pol | input | 1 | LR polarity select (R6) |
| o_left | output | 24 | Sign-extended left sample |
| o_right | output | 24 | Sign-extended right sample |
| o_valid | output | 1 | One-cycle pulse per completed frame |

## Verification
A pair of samples is due on the third system-clock rising edge after the bit-clock rise that carries the first bit of the next left half. Two cycles come from the synchroniser and one from the register that holds the outputs. The valid pulse lasts exactly one cycle.

The bench drives every serial input change on a falling system-clock edge and reads the outputs on falling edges. Each reading therefore falls half a cycle clear of the edge that produced it. A scoreboard pops one expected pair for each observed pulse. After the trailing bit of each run it waits well past the three-cycle latency and confirms the queue is empty, which catches missing pulses and extra pulses.

// File: rtl/arx_pkg.sv
`timescale 1ns/1ps
package arx_pkg;

    typedef enum logic [1:0] {
        ST_ALIGN = 2'd0,
        ST_LEFT  = 2'd1,
        ST_RIGHT = 2'd2
    } state_e;

    typedef struct packed {
        logic       rj;    // word aligned to end of half-period
        logic       rsv;   // reserved code: force zero
        logic [4:0] len;   // word length in bits
        logic [1:0] off;   // first window bit after the LR change
    } fmt_cfg_t;

endpackage

// File: rtl/arx_sync.sv
`timescale 1ns/1ps
module arx_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_in,
    output logic [N-1:0] d_sync,
    output logic         o_rise0
);
    logic [N-1:0] stg1;
    logic         dly0;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg1[i]   <= 1'b0;
                d_sync[i] <= 1'b0;
            end else begin
                stg1[i]   <= d_in[i];
                d_sync[i] <= stg1[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dly0 <= 1'b0;
        else        dly0 <= d_sync[0];
    end

    assign o_rise0 = d_sync[0] & ~dly0;

    // R10: a rising bit clock is registered in one cycle only
    a_r10_rise_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        o_rise0 |=> !o_rise0);

endmodule

// File: rtl/arx_fmt_decode.sv
`timescale 1ns/1ps
module arx_fmt_decode
    import arx_pkg::*;
(
    input  logic [2:0] fmt,
    output fmt_cfg_t   cfg
);
    always_comb begin
        cfg = '{rj: 1'b0, rsv: 1'b0, len: 5'd24, off: 2'd0};
        unique case (fmt)
            3'b000: cfg = '{rj: 1'b1, rsv: 1'b0, len: 5'd16, off: 2'd0};
            3'b001: cfg = '{rj: 1'b1, rsv: 1'b0, len: 5'd20, off: 2'd0};
            3'b010: cfg = '{rj: 1'b1, rsv: 1'b0, len: 5'd24, off: 2'd0};
            3'b011: cfg = '{rj: 1'b0, rsv: 1'b0, len: 5'd24, off: 2'd0};
            3'b100: cfg = '{rj: 1'b0, rsv: 1'b0, len: 5'd16, off: 2'd1};
            3'b101: cfg = '{rj: 1'b0, rsv: 1'b0, len: 5'd24, off: 2'd1};
            3'b110: cfg = '{rj: 1'b0, rsv: 1'b1, len: 5'd24, off: 2'd0};
            3'b111: cfg = '{rj: 1'b0, rsv: 1'b1, len: 5'd24, off: 2'd0};
        endcase
    end
endmodule

// File: rtl/arx_shift.sv
`timescale 1ns/1ps
module arx_shift
    import arx_pkg::*;
#(
    parameter int OUTW = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            i_tick,
    input  logic            i_bit,
    input  logic            i_lr_edge,
    input  fmt_cfg_t        i_cfg,
    output logic [OUTW-1:0] o_word
);
    localparam int CNTW = $clog2(OUTW + 8);
    localparam logic [CNTW-1:0] CNT_MAX = '1;

    logic [OUTW-1:0] tail_q;   // most recent bits, for right-justified
    logic [OUTW-1:0] win_q;    // counted window, for left-justified / I2S
    logic [CNTW-1:0] cnt_q;    // bits seen since the LR change
    logic [CNTW-1:0] win_lo, win_hi;
    logic            in_win;

    assign win_lo = CNTW'(i_cfg.off);
    assign win_hi = CNTW'(i_cfg.off) + CNTW'(i_cfg.len);
    assign in_win = (cnt_q >= win_lo) && (cnt_q < win_hi);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tail_q <= '0;
            win_q  <= '0;
            cnt_q  <= '0;
        end else if (i_tick) begin
            tail_q <= {tail_q[OUTW-2:0], i_bit};
            if (i_lr_edge) begin
                cnt_q <= CNTW'(1);
                win_q <= (i_cfg.off == 2'd0) ? {{(OUTW-1){1'b0}}, i_bit} : '0;
            end else begin
                if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNTW'(1);
                if (in_win) win_q <= {win_q[OUTW-2:0], i_bit};
            end
        end
    end

    logic [OUTW-1:0] raw;
    logic [4:0]      msb_idx;
    logic            sgn;

    always_comb begin
        raw     = i_cfg.rj ? tail_q : win_q;
        msb_idx = i_cfg.len - 5'd1;
        sgn     = raw[msb_idx];
        for (int i = 0; i < OUTW; i++) begin
            o_word[i] = (i < int'(i_cfg.len)) ? raw[i] : sgn;
        end
        if (i_cfg.rsv) o_word = '0;
    end

    // R9: bits after the window leave the window register untouched
    a_r9_window_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (i_tick && !i_lr_edge && !i_cfg.rj && (cnt_q >= win_hi)) |=> $stable(win_q));

endmodule

// File: rtl/audio_serial_rx.sv
`timescale 1ns/1ps
module audio_serial_rx
    import arx_pkg::*;
#(
    parameter int OUTW = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bclk,
    input  logic            lrclk,
    input  logic            sdata,
    input  logic [2:0]      fmt,
    input  logic            lr_pol,
    output logic [OUTW-1:0] o_left,
    output logic [OUTW-1:0] o_right,
    output logic            o_valid
);
    localparam int NSYNC = 3;

    logic [NSYNC-1:0] raw_in, syn;
    logic             tick;
    logic             lr_s, sd_s, lr_prev;
    logic             lr_edge, into_left;
    fmt_cfg_t         cfg;
    logic [OUTW-1:0]  word;
    logic [OUTW-1:0]  left_hold;
    state_e           state, nxt;

    assign raw_in = {sdata, lrclk, bclk};

    arx_sync #(.N(NSYNC)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_in   (raw_in),
        .d_sync (syn),
        .o_rise0(tick)
    );

    assign lr_s = syn[1];
    assign sd_s = syn[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    lr_prev <= 1'b0;
        else if (tick) lr_prev <= lr_s;
    end

    assign lr_edge   = tick && (lr_s != lr_prev);
    assign into_left = lr_s ^ lr_pol;

    arx_fmt_decode u_dec (
        .fmt(fmt),
        .cfg(cfg)
    );

    arx_shift #(.OUTW(OUTW)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .i_tick   (tick),
        .i_bit    (sd_s),
        .i_lr_edge(lr_edge),
        .i_cfg    (cfg),
        .o_word   (word)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_ALIGN;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        if (lr_edge) begin
            unique case (state)
                ST_ALIGN: nxt = into_left ? ST_LEFT  : ST_ALIGN;   // T_START
                ST_LEFT:  nxt = into_left ? ST_LEFT  : ST_RIGHT;   // T_RESYNC_L / T_L2R
                ST_RIGHT: nxt = into_left ? ST_LEFT  : ST_ALIGN;   // T_EMIT / T_RESYNC_R
                default:  nxt = ST_ALIGN;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_hold <= '0;
            o_left    <= '0;
            o_right   <= '0;
            o_valid   <= 1'b0;
        end else begin
            o_valid <= 1'b0;
            if (lr_edge) begin
                unique case (state)
                    ST_LEFT: begin
                        if (!into_left) left_hold <= word;
                    end
                    ST_RIGHT: begin
                        if (into_left) begin
                            o_left  <= left_hold;
                            o_right <= word;
                            o_valid <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R7: single-cycle pulse
    a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid |=> !o_valid);

    // R7: samples only move together with the pulse
    a_r7_samples_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !o_valid |-> ($stable(o_left) && $stable(o_right)));

    // R8: a frame is reported only when a right half has just closed
    a_r8_after_right: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid |-> ($past(state) == ST_RIGHT));

    // R5: reserved codes deliver zero
    a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && $past(cfg.rsv)) |-> (o_right == '0));

    // R2: 16-bit right-justified words arrive sign-extended
    a_r2_sext16: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && ($past(fmt) == 3'b000)) |->
        ((o_right[OUTW-1:15] == '0) || (o_right[OUTW-1:15] == '1)));

endmodule

// File: tb/audio_serial_rx_bench.sv
`timescale 1ns/1ps
module audio_serial_rx_bench;

    localparam int HB = 32;       // bits per half-period
    localparam int BH = 16;       // ns per bclk phase

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
    logic [2:0]  fmt = 3'b000;
    logic        lr_pol = 1'b0;
    logic [23:0] o_left, o_right;
    logic        o_valid;

    int    n_run = 0, n_fail = 0;
    bit    done = 0;
    string tag = "R1";
    logic [47:0] exp_q[$];

    always #2 clk = ~clk;

    audio_serial_rx u_audio_serial_rx (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
        .fmt(fmt), .lr_pol(lr_pol),
        .o_left(o_left), .o_right(o_right), .o_valid(o_valid)
    );

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] expv);
        n_run++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic int wlen(input logic [2:0] f);
        case (f)
            3'b000, 3'b100: return 16;
            3'b001:         return 20;
            default:        return 24;
        endcase
    endfunction

    function automatic logic [23:0] expect_word(input logic [2:0] f, input logic [23:0] w);
        int n = wlen(f);
        logic signed [23:0] t;
        if (f[2:1] == 2'b11) return 24'h0;
        t = $signed(w << (24 - n));
        return 24'(t >>> (24 - n));
    endfunction

    function automatic logic bit_at(input logic [2:0] f, input logic [23:0] w, input int idx);
        int n = wlen(f);
        if (f[2:1] == 2'b11) return idx[0] ^ idx[1];
        if (f == 3'b011)     return (idx < 24) ? w[23 - idx] : 1'b1;
        if (f[2]) begin
            if (idx == 0) return ~w[n - 1];
            return (idx <= n) ? w[n - idx] : 1'b1;
        end
        return (idx >= HB - n) ? w[HB - 1 - idx] : idx[0];
    endfunction

    task automatic send_bit(input logic lvl, input logic b);
        lrclk = lvl;
        sdata = b;
        #BH bclk = 1'b1;
        #BH bclk = 1'b0;
    endtask

    task automatic send_half(input logic lvl, input logic [23:0] w);
        for (int i = 0; i < HB; i++) send_bit(lvl, bit_at(fmt, w, i));
    endtask

    task automatic send_frame(input logic [23:0] l, input logic [23:0] r);
        exp_q.push_back({expect_word(fmt, l), expect_word(fmt, r)});
        send_half(~lr_pol, l);
        send_half(lr_pol, r);
    endtask

    task automatic run_group(input string t, input logic [2:0] f, input logic p,
                             input logic [23:0] a, input logic [23:0] b,
                             input logic [23:0] c, input logic [23:0] d);
        rst_n = 1'b0;
        bclk  = 1'b0;
        fmt   = f;
        lr_pol = p;
        tag   = t;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: a leading right half must not produce a frame
        for (int i = 0; i < HB; i++) send_bit(p, 1'b1);
        send_frame(a, b);
        send_frame(c, d);
        send_frame(b, a ^ 24'h5A5A5A);
        send_bit(~p, 1'b0);
        repeat (12) @(negedge clk);
        check({t, " R7 pending frames"}, 48'(exp_q.size()), 48'd0);
        exp_q.delete();
    endtask

    // scoreboard monitor
    initial begin
        logic prev_v = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && o_valid) begin
                if (prev_v) check("R7 pulse width", 48'd2, 48'd1);
                if (exp_q.size() == 0) check({tag, " R8 unexpected frame"}, {o_left, o_right}, 48'h0);
                else check({tag, " frame"}, {o_left, o_right}, exp_q.pop_front());
            end
            prev_v = rst_n && o_valid;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset valid", 48'(o_valid), 48'd0);
        check("R1 reset samples", {o_left, o_right}, 48'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 after reset", {o_left, o_right, 24'(o_valid)} == 72'd0 ? 48'd0 : 48'd1, 48'd0);

        run_group("R2 rj16",      3'b000, 1'b0, 24'h008001, 24'h007FFF, 24'hFF1234, 24'h00FFFF);
        run_group("R2 rj20",      3'b001, 1'b0, 24'h080001, 24'h07FFFF, 24'h0ABCDE, 24'h012345);
        run_group("R2 R6 rj24",   3'b010, 1'b1, 24'h800001, 24'h7FFFFF, 24'hC0FFEE, 24'h123456);
        run_group("R3 R9 lj24",   3'b011, 1'b0, 24'hA5A5A5, 24'h000001, 24'h800000, 24'h7F00FF);
        run_group("R3 R6 lj24",   3'b011, 1'b1, 24'h13579B, 24'hFFFFFF, 24'h2468AC, 24'h800000);
        run_group("R4 R6 i2s16",  3'b100, 1'b1, 24'h00C3A5, 24'h001234, 24'h008000, 24'h007FFE);
        run_group("R4 R9 i2s24",  3'b101, 1'b0, 24'hF0F0F0, 24'h0F0F0F, 24'h800001, 24'h654321);
        run_group("R5 rsv6",      3'b110, 1'b0, 24'h123456, 24'hABCDEF, 24'hFFFFFF, 24'h800000);
        run_group("R5 R6 rsv7",   3'b111, 1'b1, 24'h7FFFFF, 24'h000001, 24'h555555, 24'hAAAAAA);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #400us;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule